// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine

This block moves bytes from a source to a destination on its own, acting as a master on a byte-wide bus that has separate strobes for memory and I/O cycles. Software loads a 20-bit source address, a 20-bit destination address and a 16-bit byte count through a small register port. It then writes a control word that selects the kind of each end, the address stepping, the DREQ sense and the wait-state counts, and that sets the enable bit. Each byte takes one read cycle from the source, then one write cycle to the destination. The addresses and the count are updated after the write.

Memory-to-memory jobs run as soon as the bus is granted. A job with an I/O end is paced by the DREQ input, which is sampled as a level or as a latched rising edge. For every byte the engine reports the number of bus clocks the byte costs under the programmed wait states. It adds these up over a burst and pauses once the running total goes past a supplied budget. The burst total restarts when the grant is dropped and raised again, and the job then continues from where it stopped. TEND marks the final byte. When the count reaches zero the enable bit clears and a done flag is set.

Top module: `dma_xfer_channel`

## Requirements
- R1: After reset all four strobes and TEND are low, every register reads zero and the done flag (control readback bit 15) is clear.
- R2: Control bits [2:1] select the source: 00 memory with the address stepping up by one per byte, 01 memory stepping down by one, 10 memory held fixed, 11 I/O held fixed. The source is read with mem_rd for memory and io_rd for I/O.
- R3: Control bits [4:3] select the destination with the same encoding as R2. It is written with mem_wr for memory and io_wr for I/O.
- R4: When both source and destination select 10 (memory fixed), no strobe is issued and the count does not change while the channel stays enabled.
- R5: When neither end is I/O, bytes move with DREQ low, as long as bus_grant is high.
- R6: With control bit 5 at 0 (level sense), a job with an I/O end moves no byte while DREQ is low and moves bytes while it is high.
- R7: With control bit 5 at 1 (edge sense), each rising edge of DREQ allows exactly one byte of a job with an I/O end. Holding DREQ high does not move a second byte.
- R8: A byte is a single read-strobe cycle at the source address, followed in the next cycle by a single write-strobe cycle at the destination address that carries the byte read. At most one strobe is active in any cycle.
- R9: TEND is high during both cycles of the byte that starts with the count equal to 1, and low for all other bytes.
- R10: cost_valid pulses in the write cycle of each byte. With memory wait M (bits [7:6]) and I/O wait W (bits [9:8]), cost_clks is 6+2M for memory-to-memory bytes and 6+M+W+1 when either end is I/O.
- R11: The costs of the bytes in a burst are summed. No new byte starts once the sum exceeds cycle_budget. Dropping and raising bus_grant, or writing the control word with enable set, starts a new burst with the count and addresses preserved.
- R12: The count decrements after every byte. At the final byte the enable bit (control bit 0) clears and the done flag sets, and the done flag stays set until a control write with enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Readback of the selected register |
| bus_grant | input | 1 | Bus granted to the channel |
| cycle_budget | input | 16 | Clock budget per burst |
| dreq | input | 1 | Transfer request for I/O-paced jobs |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled in the read cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tend | output | 1 | Final-byte marker |
| cost_valid | output | 1 | Per-byte cost report valid |
| cost_clks | output | 4 | Bus clocks the current byte costs |

## Verification
The bench goes after the stepping modes in both directions and the fixed-fixed reserved pair. If the reserved pair were not decoded, the engine would keep writing the same byte to one address until the count drained. DREQ is held high across several bytes in edge mode, where a latch that is never cleared would let the whole job stream through on one edge. A level-mode job is left enabled with DREQ low, so a pacing check that is missing shows up as early strobes. The budget test stops a burst after exactly two bytes and then resumes it. A sum that never resets would hang the job, and a sum compared before it is updated would let a third byte through. Lost addresses would appear as wrong write addresses after the resume.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int WAIT_W = 2;
  localparam int CTRL_W = 10;

  typedef enum logic [1:0] {
    AM_INC = 2'b00,
    AM_DEC = 2'b01,
    AM_FIX = 2'b10,
    AM_IO  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  // Packed from MSB: io_wait [9:8] ... enable [0]
  typedef struct packed {
    logic [WAIT_W-1:0] io_wait;
    logic [WAIT_W-1:0] mem_wait;
    logic              dreq_edge;
    addr_mode_e        dst_mode;
    addr_mode_e        src_mode;
    logic              enable;
  } ctrl_t;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  addr_mode_e        mode,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load) begin
      addr_d = load_val;
    end else if (step) begin
      case (mode)
        AM_INC:  addr_d = addr_q + ADDR_W'(1);
        AM_DEC:  addr_d = addr_q - ADDR_W'(1);
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma_req_pacer.sv
module dma_req_pacer (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic edge_mode,
  input  logic consume,
  output logic req_ok
);
  logic dreq_q, latch_q, latch_d, rise;

  assign rise = dreq & ~dreq_q;

  always_comb begin
    latch_d = latch_q;
    if (rise)         latch_d = 1'b1;
    else if (consume) latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      dreq_q  <= dreq;
      latch_q <= latch_d;
    end
  end

  assign req_ok = edge_mode ? latch_q : dreq;
endmodule

// File: rtl/dma_cost_calc.sv
module dma_cost_calc #(
  parameter int WAIT_W    = 2,
  parameter int BASE_CLKS = 6,
  parameter int COST_W    = 4
) (
  input  logic              io_inv,
  input  logic [WAIT_W-1:0] mem_wait,
  input  logic [WAIT_W-1:0] io_wait,
  output logic [COST_W-1:0] cost
);
  always_comb begin
    if (io_inv)
      cost = COST_W'(BASE_CLKS) + COST_W'(mem_wait) + COST_W'(io_wait) + COST_W'(1);
    else
      cost = COST_W'(BASE_CLKS) + COST_W'(mem_wait) + COST_W'(mem_wait);
  end
endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int CNT_W     = 16,
  parameter int BUDGET_W  = 16,
  parameter int BASE_CLKS = 6,
  parameter int DATA_W    = 8,
  localparam int REG_W    = ADDR_W,
  localparam int COST_W   = $clog2(BASE_CLKS + 2 * (2**WAIT_W - 1) + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                bus_grant,
  input  logic [BUDGET_W-1:0] cycle_budget,
  input  logic                dreq,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                io_rd,
  output logic                io_wr,
  output logic                tend,
  output logic                cost_valid,
  output logic [COST_W-1:0]   cost_clks
);
  localparam int USED_W = BUDGET_W + 1;

  ctrl_t             ctrl_q, ctrl_d;
  xfer_state_e       state_q, state_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic [USED_W-1:0] used_q, used_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              done_q, done_d;

  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic              ctrl_load, count_load, src_load, dst_load;
  logic              src_io, dst_io, io_inv, reserved, over_budget;
  logic              req_ok, start, byte_done, last_byte;
  logic [COST_W-1:0] cost;

  assign ctrl_load  = reg_we && (reg_addr == 2'd3);
  assign count_load = reg_we && (reg_addr == 2'd2);
  assign dst_load   = reg_we && (reg_addr == 2'd1);
  assign src_load   = reg_we && (reg_addr == 2'd0);

  assign src_io      = (ctrl_q.src_mode == AM_IO);
  assign dst_io      = (ctrl_q.dst_mode == AM_IO);
  assign io_inv      = src_io | dst_io;
  assign reserved    = (ctrl_q.src_mode == AM_FIX) && (ctrl_q.dst_mode == AM_FIX);
  assign over_budget = used_q > {1'b0, cycle_budget};
  assign byte_done   = (state_q == ST_WRITE);
  assign last_byte   = (count_q == CNT_W'(1));

  assign start = (state_q == ST_IDLE) && ctrl_q.enable && bus_grant && !over_budget &&
                 !reserved && (count_q != '0) && (!io_inv || req_ok);

  dma_addr_unit #(.ADDR_W(ADDR_W)) u_src_addr (
    .clk(clk), .rst_n(rst_n), .load(src_load), .load_val(reg_wdata[ADDR_W-1:0]),
    .step(byte_done), .mode(ctrl_q.src_mode), .addr(src_addr)
  );

  dma_addr_unit #(.ADDR_W(ADDR_W)) u_dst_addr (
    .clk(clk), .rst_n(rst_n), .load(dst_load), .load_val(reg_wdata[ADDR_W-1:0]),
    .step(byte_done), .mode(ctrl_q.dst_mode), .addr(dst_addr)
  );

  dma_req_pacer u_pacer (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .edge_mode(ctrl_q.dreq_edge),
    .consume(byte_done && io_inv), .req_ok(req_ok)
  );

  dma_cost_calc #(.WAIT_W(WAIT_W), .BASE_CLKS(BASE_CLKS), .COST_W(COST_W)) u_cost (
    .io_inv(io_inv), .mem_wait(ctrl_q.mem_wait), .io_wait(ctrl_q.io_wait), .cost(cost)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase

    ctrl_d = ctrl_q;
    if (ctrl_load)                 ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    else if (byte_done && last_byte) ctrl_d.enable = 1'b0;

    done_d = done_q;
    if (ctrl_load && reg_wdata[0])   done_d = 1'b0;
    else if (byte_done && last_byte) done_d = 1'b1;

    count_d = count_q;
    if (count_load)     count_d = reg_wdata[CNT_W-1:0];
    else if (byte_done) count_d = count_q - CNT_W'(1);

    used_d = used_q;
    if (!bus_grant || (ctrl_load && reg_wdata[0])) used_d = '0;
    else if (byte_done) used_d = used_q + USED_W'(cost);

    data_d = data_q;
    if (state_q == ST_READ) data_d = bus_rdata;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      count_q <= '0;
      used_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      done_q  <= done_d;
      count_q <= count_d;
      used_q  <= used_d;
      data_q  <= data_d;
    end
  end

  // Bus outputs
  assign bus_addr   = (state_q == ST_READ) ? src_addr : dst_addr;
  assign bus_wdata  = data_q;
  assign mem_rd     = (state_q == ST_READ)  && !src_io;
  assign io_rd      = (state_q == ST_READ)  &&  src_io;
  assign mem_wr     = (state_q == ST_WRITE) && !dst_io;
  assign io_wr      = (state_q == ST_WRITE) &&  dst_io;
  assign tend       = (state_q != ST_IDLE) && last_byte;
  assign cost_valid = byte_done;
  assign cost_clks  = cost;

  // Register readback
  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = src_addr;
      2'd1:    reg_rdata = dst_addr;
      2'd2:    reg_rdata = REG_W'(count_q);
      default: reg_rdata = REG_W'({done_q, 5'b0, ctrl_q});
    endcase
  end
endmodule

// File: rtl/dma_xfer_channel_chk.sv
module dma_xfer_channel_chk #(
  parameter int CNT_W  = 16,
  parameter int COST_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              tend,
  input logic              cost_valid,
  input logic [COST_W-1:0] cost_clks,
  input logic              count_load,
  input logic [CNT_W-1:0]  count_q
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr})); // R8

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || io_rd) |=> (mem_wr || io_wr)); // R8

  AST_COST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cost_valid |-> (cost_clks >= COST_W'(6) && cost_clks <= COST_W'(13))); // R10

  AST_COST_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cost_valid |-> (mem_wr || io_wr)); // R10

  AST_TEND_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tend |-> (mem_rd || io_rd || mem_wr || io_wr)); // R9

  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (cost_valid && !count_load) |=> (count_q == $past(count_q) - CNT_W'(1))); // R12
endmodule

bind dma_xfer_channel dma_xfer_channel_chk #(.CNT_W(CNT_W), .COST_W(COST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
  .io_wr(io_wr), .tend(tend), .cost_valid(cost_valid), .cost_clks(cost_clks),
  .count_load(count_load), .count_q(count_q)
);

// File: tb/test_dma_xfer_channel.sv
`timescale 1ns/1ps
module test_dma_xfer_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [19:0] reg_wdata;
  logic [19:0] reg_rdata;
  logic        bus_grant;
  logic [15:0] cycle_budget;
  logic        dreq;
  logic [19:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        mem_rd, mem_wr, io_rd, io_wr, tend, cost_valid;
  logic [3:0]  cost_clks;

  always #4 clk = ~clk;

  dma_xfer_channel i_dma_xfer_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_grant(bus_grant),
    .cycle_budget(cycle_budget), .dreq(dreq), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .tend(tend), .cost_valid(cost_valid),
    .cost_clks(cost_clks)
  );

  // Bus slave model: read data depends on the address only
  assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

  typedef struct packed {
    logic [19:0] addr;
    logic        io;
    logic [7:0]  data;
    logic        tend;
    logic [3:0]  cost;
    logic [7:0]  req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  int   strobe_cnt = 0;
  logic [19:0] e_src, e_dst;
  int   e_rem;

  task automatic check(input logic ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] step(input logic [19:0] a, input logic [1:0] m);
    case (m)
      2'b00:   return a + 20'd1;
      2'b01:   return a - 20'd1;
      default: return a;
    endcase
  endfunction

  // Driver side: push expected bytes from the model state
  task automatic push_bytes(input int n, input logic [1:0] sm, input logic [1:0] dm,
                            input logic [3:0] cost, input int req);
    for (int i = 0; i < n; i++) begin
      exp_t it;
      it.addr = e_dst;
      it.io   = (dm == 2'b11);
      it.data = e_src[7:0] ^ 8'hA5;
      it.tend = (e_rem == 1);
      it.cost = cost;
      it.req  = 8'(req);
      exp_q.push_back(it);
      e_src = step(e_src, sm);
      e_dst = step(e_dst, dm);
      e_rem--;
    end
  endtask

  // Monitor: compare every write cycle with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && (mem_rd || mem_wr || io_rd || io_wr)) strobe_cnt++;
    if (rst_n && (mem_wr || io_wr)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 8, {12'h0, bus_addr}, 32'hFFFFFFFF); // R8 unexpected byte
      end else begin
        exp_t e;
        exp_t a;
        e = exp_q.pop_front();
        a.addr = bus_addr; a.io = io_wr; a.data = bus_wdata; a.tend = tend;
        a.cost = cost_valid ? cost_clks : 4'h0; a.req = e.req;
        // R2 R3 R8 R9 R10 fields compared together
        check(a == e, int'(e.req), 32'(a >> 8), 32'(e >> 8));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [19:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [19:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_done();
    logic [19:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(2'd3, v);
      if (v[15]) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, 0, 32'h0, 32'h1); // watchdog expired
    finish_run();
  end

  initial begin
    logic [19:0] v;
    int s0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    bus_grant = 1'b1; cycle_budget = 16'hFFFF; dreq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check({mem_rd, mem_wr, io_rd, io_wr, tend} == 5'b0, 1, 32'({mem_rd, mem_wr, io_rd, io_wr, tend}), 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(2'(k), v);
      check(v == 20'h0, 1, 32'(v), 32'h0); // R1
    end

    // Job A: mem inc -> mem inc, 3 bytes, memory wait 1 (R2 R3 R5 R9 R10 R12)
    wr(2'd0, 20'h00100); wr(2'd1, 20'h02000); wr(2'd2, 20'd3);
    e_src = 20'h00100; e_dst = 20'h02000; e_rem = 3;
    push_bytes(3, 2'b00, 2'b00, 4'd8, 10);
    wr(2'd3, 20'h00041);
    wait_done();
    rd(2'd3, v); check(v == 20'h08040, 12, 32'(v), 32'h08040); // R12 enable off, done on
    rd(2'd2, v); check(v == 20'h0, 12, 32'(v), 32'h0);         // R12 count zero
    rd(2'd0, v); check(v == 20'h00103, 2, 32'(v), 32'h00103);  // R2 stepped up
    rd(2'd1, v); check(v == 20'h02003, 3, 32'(v), 32'h02003);  // R3 stepped up
    wr(2'd3, 20'h00041);
    rd(2'd3, v); check(v == 20'h00041, 12, 32'(v), 32'h00041); // R12 done cleared
    wr(2'd3, 20'h00000);

    // Job B: mem dec -> mem fixed, memory wait 3 (R2 R3 R10)
    wr(2'd0, 20'h00050); wr(2'd1, 20'h03000); wr(2'd2, 20'd2);
    e_src = 20'h00050; e_dst = 20'h03000; e_rem = 2;
    push_bytes(2, 2'b01, 2'b10, 4'd12, 10);
    wr(2'd3, 20'h000D3);
    wait_done();
    rd(2'd0, v); check(v == 20'h0004E, 2, 32'(v), 32'h0004E);  // R2 stepped down
    rd(2'd1, v); check(v == 20'h03000, 3, 32'(v), 32'h03000);  // R3 held

    // Job C: reserved fixed/fixed pair (R4)
    wr(2'd0, 20'h00010); wr(2'd1, 20'h00020); wr(2'd2, 20'd4);
    s0 = strobe_cnt;
    wr(2'd3, 20'h00015);
    idle(30);
    check(strobe_cnt == s0, 4, 32'(strobe_cnt - s0), 32'h0);  // R4 no strobes
    rd(2'd2, v); check(v == 20'd4, 4, 32'(v), 32'd4);          // R4 count kept
    wr(2'd3, 20'h00000);

    // Job D: I/O source to mem dec, level DREQ, I/O wait 2 (R6 R10)
    wr(2'd0, 20'h00040); wr(2'd1, 20'h04000); wr(2'd2, 20'd2);
    e_src = 20'h00040; e_dst = 20'h04000; e_rem = 2;
    s0 = strobe_cnt;
    wr(2'd3, 20'h0020F);
    idle(20);
    check(strobe_cnt == s0, 6, 32'(strobe_cnt - s0), 32'h0);  // R6 held off
    rd(2'd2, v); check(v == 20'd2, 6, 32'(v), 32'd2);
    push_bytes(2, 2'b11, 2'b01, 4'd9, 6);
    @(negedge clk); dreq = 1'b1;
    wait_done();
    @(negedge clk); dreq = 1'b0;
    rd(2'd1, v); check(v == 20'h03FFE, 3, 32'(v), 32'h03FFE);  // R3 stepped down

    // Job E: mem inc -> I/O, edge DREQ, memory wait 1 (R7)
    wr(2'd0, 20'h00200); wr(2'd1, 20'h00077); wr(2'd2, 20'd3);
    e_src = 20'h00200; e_dst = 20'h00077; e_rem = 3;
    s0 = strobe_cnt;
    wr(2'd3, 20'h00079);
    idle(10);
    check(strobe_cnt == s0, 7, 32'(strobe_cnt - s0), 32'h0);  // R7 no edge yet
    for (int b = 0; b < 3; b++) begin
      push_bytes(1, 2'b00, 2'b11, 4'd8, 7);
      @(negedge clk); dreq = 1'b1;
      idle(20);
      rd(2'd2, v); check(v == 20'(2 - b), 7, 32'(v), 32'(2 - b)); // R7 one byte per edge
      @(negedge clk); dreq = 1'b0;
    end

    // Job F: budget 10 with 6-clock bytes gives two bytes per burst (R11)
    cycle_budget = 16'd10;
    wr(2'd0, 20'h00300); wr(2'd1, 20'h00500); wr(2'd2, 20'd5);
    e_src = 20'h00300; e_dst = 20'h00500; e_rem = 5;
    push_bytes(2, 2'b00, 2'b00, 4'd6, 11);
    s0 = strobe_cnt;
    wr(2'd3, 20'h00001);
    idle(30);
    check(strobe_cnt - s0 == 4, 11, 32'(strobe_cnt - s0), 32'd4); // R11 burst stopped
    rd(2'd2, v); check(v == 20'd3, 11, 32'(v), 32'd3);
    rd(2'd0, v); check(v == 20'h00302, 11, 32'(v), 32'h00302);
    push_bytes(2, 2'b00, 2'b00, 4'd6, 11);
    @(negedge clk); bus_grant = 1'b0;
    idle(2); bus_grant = 1'b1;
    idle(30);
    rd(2'd2, v); check(v == 20'd1, 11, 32'(v), 32'd1);         // R11 resumed
    push_bytes(1, 2'b00, 2'b00, 4'd6, 11);
    @(negedge clk); bus_grant = 1'b0;
    idle(2); bus_grant = 1'b1;
    wait_done();
    rd(2'd1, v); check(v == 20'h00505, 11, 32'(v), 32'h00505);
    cycle_budget = 16'hFFFF;

    idle(5);
    check(exp_q.size() == 0, 8, 32'(exp_q.size()), 32'h0);     // R8 all bytes seen
    finish_run();
  end
endmodule